// File: doc/BRIEF.md
# EDO DRAM Controller with CAS-before-RAS Refresh

This block connects a simple host request port to one asynchronous EDO DRAM of 8M bytes. The host offers one read or write at a time with a valid/ready handshake, a 23-bit byte address and an 8-bit data byte. The controller splits the address into a 12-bit row and an 11-bit column and places them one after the other on the 12 multiplexed address pins. It drives the row strobe, column strobe, write enable and output enable, and the data pins through a separate output, output-enable and input.

The controller leaves a row open after an access. A later request to the same row becomes a page cycle with only a column strobe. A request to another row first closes the open row and waits out the precharge and the row-cycle time. An interval counter asks for one refresh every period divided by the row count. A pending refresh stops new requests from being accepted. It is served with the column strobe falling before the row strobe, once the current access has finished and the row is closed. All timing values are given in clock cycles through parameters.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The row is `req_addr[22:11]` and is on `dram_addr` when `dram_ras_n` falls. The column is `{1'b0, req_addr[10:0]}` and is on `dram_addr` when `dram_cas_n` falls for an access.
- R2: In a write, `dram_we_n` is low and `dram_oe_n` is high. `dram_dq_oe` is high only while `dram_cas_n` is low, and `dram_dq_out` then carries the accepted byte.
- R3: In a read, `dram_oe_n` is low and `dram_dq_oe` stays low. The byte is sampled in the last of CASL cycles with `dram_cas_n` low, where CASL is the largest of T_CAC, T_AA and T_RAC−T_RCD. It appears on `rsp_rdata` with a one-cycle `rsp_valid` pulse in the next cycle, and it equals the byte last written to that address.
- R4: An accepted request to the row that is currently open is served with no new fall of `dram_ras_n`.
- R5: Each fall of `dram_ras_n` follows at least T_RP cycles with it high, and comes at least T_RC cycles after the previous fall.
- R6: `dram_ras_n` stays low for at least T_RAS cycles each time it falls.
- R7: Refresh has `dram_cas_n` low for at least T_CSR cycles before `dram_ras_n` falls, with `dram_we_n` high. Any ROWS consecutive refreshes span at most REF_PERIOD_CYC cycles.
- R8: From the start of a refresh until its row strobe rises, `req_ready` is low. A pending refresh is served before any new host request.
- R9: After reset all four strobes are high, `dram_dq_oe` and `rsp_valid` are low, and `req_ready` is high.
- R10: `dram_we_n` and `dram_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data toward the pads |
| dram_dq_oe | output | 1 | Pad drive enable |
| dram_dq_in | input | 8 | Data from the pads |

## Verification
The assertions assume that the DRAM returns a valid byte by the sampling cycle. They also assume that a refresh is always served in less than one refresh interval, so a new tick never finds an earlier refresh still pending. The bench holds each request stable until it is accepted. Its DRAM model returns a junk byte until the column strobe has been low for the access time, so a read sampled too early shows up as a data mismatch. The refresh interval is set many times longer than the worst service delay of a single access plus its row close.

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int ADDR_W = 23;
  localparam int DATA_W = 8;
  localparam int ROW_W  = 12;
  localparam int COL_W  = ADDR_W - ROW_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_CAS, ST_CASHI, ST_PRE, ST_RCAS, ST_RRAS
  } edo_state_e;

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  // cycles the column strobe stays low before read data may be taken
  function automatic int cas_len(input int tcac, input int taa, input int trac, input int trcd);
    int m;
    m = tcac;
    if (taa > m) m = taa;
    if (trac - trcd > m) m = trac - trcd;
    return m;
  endfunction
endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_start,
  output logic ref_pend,
  output logic tick
);
  localparam int CW = $clog2(INTERVAL + 1);
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      ref_pend <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)           ref_pend <= 1'b1;
      else if (ref_start) ref_pend <= 1'b0;
    end
  end

  // R7
  no_lost_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (!ref_pend || ref_start));
endmodule

// File: rtl/edo_ctrl_fsm.sv
module edo_ctrl_fsm
  import edo_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int CASL  = 3,
  parameter int T_CP  = 2,
  parameter int T_RP  = 3,
  parameter int T_RAS = 5,
  parameter int T_RC  = 9,
  parameter int T_CSR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              ref_pend,
  output logic              req_ready,
  output logic              accept,
  output logic              ref_start,
  output edo_state_e        state,
  output logic              row_open,
  output logic [ROW_W-1:0]  open_row,
  output logic [COL_W-1:0]  cur_col,
  output logic              cur_write,
  output logic              sample
);
  localparam int WW = $clog2(T_RC + T_RAS + T_RCD + CASL + T_CP + T_RP + T_CSR + 2);

  logic [WW-1:0] wcnt, rc_cnt;
  edo_state_e    nxt;
  logic          hit, ras_len_ok, rc_ok, pre_ok;

  assign hit        = row_open && (row_of(req_addr) == open_row);
  assign ras_len_ok = (int'(rc_cnt) + 1) >= T_RAS;
  assign rc_ok      = (int'(rc_cnt) + 1) >= T_RC;
  assign pre_ok     = ((int'(wcnt) + 1) >= T_RP) && rc_ok;
  assign req_ready  = (state == ST_IDLE) && !ref_pend && (!row_open || hit);
  assign accept     = req_valid && req_ready;
  assign ref_start  = (state == ST_IDLE) && !row_open && ref_pend;
  assign sample     = (state == ST_CAS) && (int'(wcnt) == CASL - 1) && !cur_write;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (row_open) begin
          if (accept) nxt = ST_CAS;
          else if ((ref_pend || req_valid) && ras_len_ok) nxt = ST_PRE;
        end else if (ref_start) nxt = ST_RCAS;
        else if (accept) nxt = ST_ACT;
      end
      ST_ACT:   if (int'(wcnt) == T_RCD - 1) nxt = ST_CAS;
      ST_CAS:   if (int'(wcnt) == CASL - 1)  nxt = ST_CASHI;
      ST_CASHI: if (int'(wcnt) == T_CP - 1)  nxt = ST_IDLE;
      ST_PRE:   if (pre_ok)                  nxt = ST_IDLE;
      ST_RCAS:  if (int'(wcnt) == T_CSR - 1) nxt = ST_RRAS;
      ST_RRAS:  if (int'(wcnt) == T_RAS - 1) nxt = ST_PRE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wcnt      <= '0;
      rc_cnt    <= '1;
      row_open  <= 1'b0;
      open_row  <= '0;
      cur_col   <= '0;
      cur_write <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state)    wcnt <= '0;
      else if (wcnt != '1) wcnt <= wcnt + 1'b1;
      if ((nxt == ST_ACT && state != ST_ACT) || (nxt == ST_RRAS && state != ST_RRAS))
        rc_cnt <= '0;
      else if (rc_cnt != '1)
        rc_cnt <= rc_cnt + 1'b1;
      if (state == ST_IDLE && nxt == ST_PRE) row_open <= 1'b0;
      else if (state == ST_ACT)              row_open <= 1'b1;
      if (accept) begin
        open_row  <= row_of(req_addr);
        cur_col   <= col_of(req_addr);
        cur_write <= req_write;
      end
    end
  end

  // R4
  page_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && accept && row_open) |=> (state == ST_CAS));

  // R7
  cbr_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RCAS) |-> !row_open);
endmodule

// File: rtl/edo_io_path.sv
module edo_io_path
  import edo_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RAS = 5,
  parameter int T_RC  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  edo_state_e        state,
  input  logic              row_open,
  input  logic [ROW_W-1:0]  open_row,
  input  logic [COL_W-1:0]  cur_col,
  input  logic              cur_write,
  input  logic              accept,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              sample,
  input  logic [DATA_W-1:0] dram_dq_in,
  output logic [ROW_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int CW = $clog2(T_RC + T_RP + T_RAS + 2) + 1;

  logic [DATA_W-1:0] wdata_q;
  logic              in_col;

  assign in_col      = (state == ST_CAS) || (state == ST_CASHI);
  assign dram_addr   = in_col ? {{(ROW_W - COL_W){1'b0}}, cur_col} : open_row;
  assign dram_ras_n  = !(row_open || state == ST_ACT || state == ST_RRAS);
  assign dram_cas_n  = !(state == ST_CAS || state == ST_RCAS || state == ST_RRAS);
  assign dram_we_n   = !(state == ST_CAS && cur_write);
  assign dram_oe_n   = !(state == ST_CAS && !cur_write);
  assign dram_dq_oe  = (state == ST_CAS) && cur_write;
  assign dram_dq_out = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept) wdata_q <= req_wdata;
      rsp_valid <= sample;
      if (sample) rsp_rdata <= dram_dq_in;
    end
  end

  // pin-level strobe timers used only by the checks below
  logic [CW-1:0] hi_cnt, lo_cnt, gap_cnt;
  logic          ras_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt  <= '1;
      lo_cnt  <= '0;
      gap_cnt <= '1;
      ras_q   <= 1'b1;
    end else begin
      ras_q <= dram_ras_n;
      if (dram_ras_n) begin
        lo_cnt <= '0;
        if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      end
      if (ras_q && !dram_ras_n) gap_cnt <= CW'(1);
      else if (gap_cnt != '1)   gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R5
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (int'(hi_cnt) >= T_RP));

  // R5
  row_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (int'(gap_cnt) >= T_RC));

  // R6
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> (int'(lo_cnt) >= T_RAS));

  // R10
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dram_we_n && !dram_oe_n));

  // R2
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> (!dram_cas_n && !dram_we_n && dram_oe_n));
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int T_RCD          = 2,
  parameter int T_RAC          = 5,
  parameter int T_CAC          = 2,
  parameter int T_AA           = 3,
  parameter int T_CP           = 2,
  parameter int T_RP           = 3,
  parameter int T_RAS          = 5,
  parameter int T_RC           = 9,
  parameter int T_CSR          = 1,
  parameter int ROWS           = 4096,
  parameter int REF_PERIOD_CYC = 6400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ROW_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int CASL     = cas_len(T_CAC, T_AA, T_RAC, T_RCD);
  localparam int INTERVAL = REF_PERIOD_CYC / ROWS;

  logic             ref_pend, ref_tick, ref_start, accept, row_open, cur_write, sample;
  edo_state_e       state;
  logic [ROW_W-1:0] open_row;
  logic [COL_W-1:0] cur_col;

  edo_refresh_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_start(ref_start), .ref_pend(ref_pend), .tick(ref_tick)
  );

  edo_ctrl_fsm #(
    .T_RCD(T_RCD), .CASL(CASL), .T_CP(T_CP), .T_RP(T_RP),
    .T_RAS(T_RAS), .T_RC(T_RC), .T_CSR(T_CSR)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .ref_pend(ref_pend), .req_ready(req_ready), .accept(accept),
    .ref_start(ref_start), .state(state), .row_open(row_open), .open_row(open_row),
    .cur_col(cur_col), .cur_write(cur_write), .sample(sample)
  );

  edo_io_path #(.T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC)) u_io (
    .clk(clk), .rst_n(rst_n), .state(state), .row_open(row_open), .open_row(open_row),
    .cur_col(cur_col), .cur_write(cur_write), .accept(accept), .req_wdata(req_wdata),
    .sample(sample), .dram_dq_in(dram_dq_in), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // R8
  refresh_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && !row_open && state == ST_IDLE) |=> (state == ST_RCAS));
endmodule

// File: tb/edo_dram_ctrl_tb.sv
module edo_dram_ctrl_tb;
  localparam int ROWS_TB  = 16;
  localparam int PERIOD   = 4800;
  localparam int INTERVAL = PERIOD / ROWS_TB;
  localparam int T_RP = 3, T_RC = 9, T_RAS = 5, T_CSR = 1;
  localparam int CASL = 3;   // largest of tCAC=2, tAA=3, tRAC-tRCD=5-2

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [7:0] req_wdata = '0, dram_dq_in = '0;
  logic req_ready, rsp_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [7:0] rsp_rdata, dram_dq_out;
  logic [11:0] dram_addr;

  always #2.5 clk = ~clk;

  edo_dram_ctrl #(.ROWS(ROWS_TB), .REF_PERIOD_CYC(PERIOD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "R8 watchdog expired", cyc, 150000);
      finish_run();
    end
  end

  // ---------------- behavioural DRAM with timing checks ----------------
  logic [7:0] mem [int];
  logic [11:0] m_row = '0, m_col = '0, last_row = '0, last_col = '0;
  bit ras_prev = 1'b1, cas_prev = 1'b1, in_ref = 1'b0;
  int ras_hi = 1000, ras_lo = 0, gap = 1000, cas_lo = 0;
  int ras_falls = 0, ref_cnt = 0, windows = 0;
  int viol_r2 = 0, viol_r3 = 0, viol_r8 = 0, viol_r10 = 0;
  int rt [ROWS_TB];

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dram_we_n && !dram_oe_n) viol_r10++;
      if (dram_dq_oe && (dram_cas_n || dram_we_n || !dram_oe_n)) viol_r2++;
      if (!dram_oe_n && dram_dq_oe) viol_r3++;
      if (in_ref && req_valid && req_ready) viol_r8++;
      // column strobe falling
      if (cas_prev && !dram_cas_n) begin
        if (dram_ras_n) in_ref = 1'b1;
        else begin
          m_col = dram_addr; last_row = m_row; last_col = m_col;
          if (!dram_we_n) mem[int'({m_row, m_col[10:0]})] = dram_dq_out;
        end
      end
      // row strobe falling
      if (ras_prev && !dram_ras_n) begin
        check(ras_hi >= T_RP, "R5 precharge cycles", ras_hi, T_RP);
        check(gap >= T_RC, "R5 row cycle", gap, T_RC);
        ras_falls++;
        if (!dram_cas_n) begin
          check(cas_lo >= T_CSR && dram_we_n, "R7 cas-before-ras setup", cas_lo, T_CSR);
          if (ref_cnt >= ROWS_TB - 1) begin
            windows++;
            check(cyc - rt[(ref_cnt + 1) % ROWS_TB] <= PERIOD, "R7 refresh window",
                  cyc - rt[(ref_cnt + 1) % ROWS_TB], PERIOD);
          end
          rt[ref_cnt % ROWS_TB] = cyc;
          ref_cnt++;
        end else m_row = dram_addr;
      end
      if (!ras_prev && dram_ras_n) begin
        check(ras_lo >= T_RAS, "R6 row strobe width", ras_lo, T_RAS);
        in_ref = 1'b0;
      end
      // read data appears only after the access time
      if (!dram_cas_n && !dram_ras_n && !in_ref && dram_we_n)
        dram_dq_in <= (cas_lo + 1 >= CASL)
          ? (mem.exists(int'({m_row, m_col[10:0]})) ? mem[int'({m_row, m_col[10:0]})] : 8'h00)
          : 8'hEE;
      gap = (ras_prev && !dram_ras_n) ? 1 : gap + 1;
      if (dram_ras_n) begin ras_hi++; ras_lo = 0; end else begin ras_hi = 0; ras_lo++; end
      cas_lo = dram_cas_n ? 0 : cas_lo + 1;
      ras_prev = dram_ras_n;
      cas_prev = dram_cas_n;
    end
  end

  // ---------------- host side ----------------
  logic [7:0] shadow [int];

  task automatic host(input bit wr, input logic [22:0] a, input logic [7:0] d,
                      output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = 8'h00;
    if (wr) shadow[int'(a)] = d;
    else begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_rdata;
    end
  endtask

  // [31] write, [30:8] address, [7:0] write byte
  localparam logic [31:0] VEC [12] = '{
    {1'b1, 23'h000000, 8'h11}, {1'b1, 23'h000005, 8'h22}, {1'b1, 23'h000800, 8'h33},
    {1'b1, 23'h7FFFFF, 8'h44}, {1'b1, 23'h7FF800, 8'h55}, {1'b0, 23'h000005, 8'h00},
    {1'b0, 23'h000000, 8'h00}, {1'b0, 23'h000800, 8'h00}, {1'b0, 23'h7FFFFF, 8'h00},
    {1'b1, 23'h000005, 8'h66}, {1'b0, 23'h000005, 8'h00}, {1'b0, 23'h7FF800, 8'h00}
  };

  initial begin
    logic [7:0] rd;
    int f0, r0, start_cyc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R9 strobes high",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    check(!dram_dq_oe && !rsp_valid, "R9 bus and response idle", {dram_dq_oe, rsp_valid}, 0);
    check(req_ready, "R9 ready after reset", req_ready, 1);
    start_cyc = cyc;

    // table walk: writes, page hits, row misses, read-back (R3)
    for (int i = 0; i < 12; i++) begin
      host(VEC[i][31], VEC[i][30:8], VEC[i][7:0], rd);
      if (!VEC[i][31])
        check(rd == shadow[int'(VEC[i][30:8])], "R3 table read-back", rd,
              shadow[int'(VEC[i][30:8])]);
    end

    // R1 address split
    host(1'b1, 23'h5A5A5A, 8'hC3, rd);
    repeat (8) @(negedge clk);
    check(last_row == 12'hB4B, "R1 row address", last_row, 12'hB4B);
    check(last_col == 12'h25A, "R1 column address", last_col, 12'h25A);

    // R4 page hit: no new row strobe unless a refresh closed the row
    host(1'b0, 23'h5A5A00, 8'h00, rd);
    f0 = ras_falls; r0 = ref_cnt;
    host(1'b0, 23'h5A5A5A, 8'h00, rd);
    check(rd == 8'hC3, "R3 page read data", rd, 8'hC3);
    check(ras_falls - f0 == ((ref_cnt == r0) ? 0 : (ref_cnt - r0) + 1), "R4 page hit row strobes",
          ras_falls - f0, (ref_cnt == r0) ? 0 : (ref_cnt - r0) + 1);

    // R5 row miss opens a new row
    f0 = ras_falls;
    host(1'b0, 23'h000800, 8'h00, rd);
    check(ras_falls - f0 >= 1, "R5 row miss reopens", ras_falls - f0, 1);
    check(rd == 8'h33, "R3 miss read data", rd, 8'h33);

    // heavy traffic with refresh preemption (R3, R8)
    for (int i = 0; i < 40; i++)
      host(1'b1, 23'(i * 32'h13579 + 32'h2468), 8'(i * 7 + 3), rd);
    for (int i = 0; i < 40; i++) begin
      host(1'b0, 23'(i * 32'h13579 + 32'h2468), 8'h00, rd);
      check(rd == shadow[int'(23'(i * 32'h13579 + 32'h2468))], "R3 traffic read-back", rd,
            shadow[int'(23'(i * 32'h13579 + 32'h2468))]);
    end

    // idle long enough for refresh windows (R7)
    repeat (ROWS_TB * INTERVAL + 2 * INTERVAL) @(negedge clk);
    check(ref_cnt >= (cyc - start_cyc) / INTERVAL - 1, "R7 refresh count", ref_cnt,
          (cyc - start_cyc) / INTERVAL - 1);
    check(windows > 0, "R7 window evaluated", windows, 1);

    check(viol_r2 == 0, "R2 bus drive outside write strobe", viol_r2, 0);
    check(viol_r3 == 0, "R3 bus driven during read", viol_r3, 0);
    check(viol_r8 == 0, "R8 request accepted during refresh", viol_r8, 0);
    check(viol_r10 == 0, "R10 write and output enable both low", viol_r10, 0);
    finish_run();
  end
endmodule